// File: doc/BRIEF.md
# Phase-Shifted Bridge Leg PWM Generator

This block drives the two switches of one leg of a phase-shifted full bridge. An up-counting timebase runs from 0 to an active period value and then wraps to 0. The period is written to a shadow input and copied into the active period only when the counter is at zero. A master timebase, with phase loading disabled, flags each zero with a sync-out pulse. A slave timebase, with phase loading enabled, copies its phase input into the counter on a sync-in pulse. Changing that phase input shifts the slave leg against the master.

Two events are decoded from the counter: zero and compare. Both use exact equality only. A phase load that carries the counter past zero or past the compare value therefore loses that event for one period, and software recovers the missed edge with the force inputs. An action-qualifier state machine (states `AQ_LOW`, `AQ_HIGH`) turns the events into a qualified drive signal. Its transitions are:
- ZERO_SET: `AQ_LOW` to `AQ_HIGH` on a zero event without a compare event.
- CMP_CLEAR: `AQ_HIGH` to `AQ_LOW` on a compare event.
- FORCE: either state to the forced level.

A dead-band state machine (states `DB_B_ON`, `DB_DLY_A`, `DB_A_ON`, `DB_DLY_B`) produces output A from the qualified signal and output B from its complement. Its transitions are:
- Q_RISE: `DB_B_ON` or `DB_DLY_B` to `DB_DLY_A`, or straight to `DB_A_ON` when the rising delay is 0.
- RISE_DONE: `DB_DLY_A` to `DB_A_ON` once the rising count has elapsed.
- Q_FALL: `DB_A_ON` or `DB_DLY_A` to `DB_DLY_B`, or straight to `DB_B_ON` when the falling delay is 0.
- FALL_DONE: `DB_DLY_B` to `DB_B_ON` once the falling count has elapsed.

In both delay states both outputs are held low.

Top module: `pwm_phase_leg`

## Requirements
- R1: After reset the counter steps by one per clock from 0 up to the active period and then returns to 0. It wraps at or above the active period. A period of 1500 with compare 750 is supported.
- R2: The shadow period is copied into the active period in every cycle in which the counter is 0. A shadow change made mid-period takes effect only for the period that follows the next zero.
- R3: `sync_out_o` is high exactly in the cycles in which `cnt_o` is 0.
- R4: When `phs_en_i` and `sync_in_i` are both high in a cycle, the counter's next value is `phs_i`. When `phs_en_i` is low, `sync_in_i` has no effect.
- R5: Zero and compare events fire only when the counter equals the target exactly. A phase jump over zero or over the compare value produces no event for that period, so the output keeps its previous level.
- R6: In a cycle in which a phase load occurs, neither event is evaluated on the pre-load counter value.
- R7: The zero event raises the qualified signal and the compare event lowers it. Both act one clock later. When both events occur together, the compare wins, so compare 0 keeps A low.
- R8: With both delays 0, output A rises two clocks after the counter is at zero and falls two clocks after it equals compare. Output B is the exact complement of A.
- R9: The rising delay postpones each rise of A by `rise_dly_i` clocks. The falling delay postpones each rise of B by `fall_dly_i` clocks. Both outputs are low during a delay, and A and B are never high together.
- R10: The force codes are 2'b00 none, 2'b01 low, 2'b10 high and 2'b11 none. A force on A sets the qualified signal to that level. A force on B sets the qualified signal to the opposite level. The force on A wins over the force on B, and any force overrides that cycle's events. The forced level persists until the next event.
- R11: During reset the counter is 0, A is low and B is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prd_shadow_i | input | CW | Shadow period value |
| cmp_i | input | CW | Compare value |
| phs_i | input | CW | Phase value loaded on sync |
| phs_en_i | input | 1 | Enable phase load on sync-in |
| sync_in_i | input | 1 | Sync pulse from master |
| rise_dly_i | input | DBW | Rising-edge dead-band, clocks |
| fall_dly_i | input | DBW | Falling-edge dead-band, clocks |
| frc_a_i | input | 2 | Force code for output A |
| frc_b_i | input | 2 | Force code for output B |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |
| sync_out_o | output | 1 | Counter-at-zero pulse |
| cnt_o | output | CW | Counter value |

## Verification
The counter and the sync-out pulse are checked in the same cycle, against the counter value seen one clock earlier. A phase load shows in `cnt_o` one clock after the sync-in edge.

A qualified transition lands one clock after its event. Each output rise then lands one further clock plus its dead-band count later, and each output fall lands one clock after the qualified change. A force therefore appears on A or B two clocks after it is applied when the delays are 0.

The bench drives inputs on falling edges. It keys each expected output level to the value of `cnt_o` observed at the same falling edge, so every check falls on the cycle those latencies predict.

// File: rtl/pwm_leg_pkg.sv
package pwm_leg_pkg;

    typedef enum logic {
        AQ_LOW  = 1'b0,
        AQ_HIGH = 1'b1
    } aq_state_t;

    typedef enum logic [1:0] {
        DB_B_ON  = 2'd0,
        DB_DLY_A = 2'd1,
        DB_A_ON  = 2'd2,
        DB_DLY_B = 2'd3
    } db_state_t;

    typedef struct packed {
        logic zero;
        logic cmp;
    } evt_t;

    localparam logic [1:0] FRC_LOW  = 2'b01;
    localparam logic [1:0] FRC_HIGH = 2'b10;

endpackage

// File: rtl/pwm_leg_timebase.sv
module pwm_leg_timebase
    import pwm_leg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] prd_shadow,
    input  logic [CW-1:0] cmp_val,
    input  logic [CW-1:0] phs_val,
    input  logic          phs_en,
    input  logic          sync_in,
    output logic [CW-1:0] cnt,
    output evt_t          evt,
    output logic          sync_out
);

    logic [CW-1:0] prd_act;
    logic          load;

    assign load = phs_en & sync_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            prd_act <= '0;
        end else begin
            if (cnt == '0)
                prd_act <= prd_shadow;
            if (load)
                cnt <= phs_val;
            else if (cnt >= prd_act)
                cnt <= '0;
            else
                cnt <= cnt + CW'(1);
        end
    end

    // exact-equality event decode, suppressed in a phase-load cycle
    assign evt.zero = !load && (cnt == '0);
    assign evt.cmp  = !load && (cnt == cmp_val);
    assign sync_out = (cnt == '0);

    a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt < prd_act) |=> cnt == $past(cnt) + CW'(1));
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt >= prd_act) |=> cnt == '0);
    a_r4_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(phs_val));
    a_r2_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> prd_act == $past(prd_act));
    a_r2_shadow_take: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> prd_act == $past(prd_shadow));

endmodule

// File: rtl/pwm_leg_qualifier.sv
module pwm_leg_qualifier
    import pwm_leg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  evt_t       evt,
    input  logic [1:0] frc_a,
    input  logic [1:0] frc_b,
    output logic       q
);

    aq_state_t st, st_nxt;
    logic      no_force;

    assign no_force = (frc_a != FRC_LOW) && (frc_a != FRC_HIGH) &&
                      (frc_b != FRC_LOW) && (frc_b != FRC_HIGH);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= AQ_LOW;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            AQ_LOW:  if (evt.zero && !evt.cmp) st_nxt = AQ_HIGH;  // ZERO_SET
            AQ_HIGH: if (evt.cmp)              st_nxt = AQ_LOW;   // CMP_CLEAR
        endcase
        // FORCE: A has priority over B, both over events
        if (frc_a == FRC_HIGH)      st_nxt = AQ_HIGH;
        else if (frc_a == FRC_LOW)  st_nxt = AQ_LOW;
        else if (frc_b == FRC_HIGH) st_nxt = AQ_LOW;
        else if (frc_b == FRC_LOW)  st_nxt = AQ_HIGH;
    end

    assign q = (st == AQ_HIGH);

    a_r7_cmp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.cmp && no_force) |=> !q);
    a_r7_zero_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.zero && !evt.cmp && no_force) |=> q);
    a_r10_force_a_high: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_a == FRC_HIGH) |=> q);
    a_r10_force_b_high: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_b == FRC_HIGH && frc_a != FRC_LOW && frc_a != FRC_HIGH) |=> !q);

endmodule

// File: rtl/pwm_leg_deadband.sv
module pwm_leg_deadband
    import pwm_leg_pkg::*;
#(
    parameter int DBW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           q,
    input  logic [DBW-1:0] rise_dly,
    input  logic [DBW-1:0] fall_dly,
    output logic           a_o,
    output logic           b_o
);

    db_state_t      st, st_nxt;
    logic [DBW-1:0] ctr, ctr_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= DB_B_ON;
            ctr <= '0;
        end else begin
            st  <= st_nxt;
            ctr <= ctr_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        ctr_nxt = ctr;
        unique case (st)
            DB_B_ON: begin
                if (q) begin                                   // Q_RISE
                    if (rise_dly == '0) st_nxt = DB_A_ON;
                    else begin st_nxt = DB_DLY_A; ctr_nxt = DBW'(1); end
                end
            end
            DB_DLY_A: begin
                if (!q) begin                                  // Q_FALL
                    if (fall_dly == '0) st_nxt = DB_B_ON;
                    else begin st_nxt = DB_DLY_B; ctr_nxt = DBW'(1); end
                end else if (ctr >= rise_dly) st_nxt = DB_A_ON; // RISE_DONE
                else ctr_nxt = ctr + DBW'(1);
            end
            DB_A_ON: begin
                if (!q) begin                                  // Q_FALL
                    if (fall_dly == '0) st_nxt = DB_B_ON;
                    else begin st_nxt = DB_DLY_B; ctr_nxt = DBW'(1); end
                end
            end
            DB_DLY_B: begin
                if (q) begin                                   // Q_RISE
                    if (rise_dly == '0) st_nxt = DB_A_ON;
                    else begin st_nxt = DB_DLY_A; ctr_nxt = DBW'(1); end
                end else if (ctr >= fall_dly) st_nxt = DB_B_ON; // FALL_DONE
                else ctr_nxt = ctr + DBW'(1);
            end
        endcase
    end

    always_comb begin
        a_o = (st == DB_A_ON);
        b_o = (st == DB_B_ON);
    end

    a_r9_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_o && b_o));
    a_r9_rise_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DB_DLY_A && q && ctr < rise_dly) |=> !a_o);
    a_r9_fall_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DB_DLY_B && !q && ctr < fall_dly) |=> !b_o);
    a_r8_q_low_drops_a: assert property (@(posedge clk) disable iff (!rst_n)
        !q |=> !a_o);

endmodule

// File: rtl/pwm_phase_leg.sv
module pwm_phase_leg
    import pwm_leg_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DBW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  prd_shadow_i,
    input  logic [CW-1:0]  cmp_i,
    input  logic [CW-1:0]  phs_i,
    input  logic           phs_en_i,
    input  logic           sync_in_i,
    input  logic [DBW-1:0] rise_dly_i,
    input  logic [DBW-1:0] fall_dly_i,
    input  logic [1:0]     frc_a_i,
    input  logic [1:0]     frc_b_i,
    output logic           pwm_a_o,
    output logic           pwm_b_o,
    output logic           sync_out_o,
    output logic [CW-1:0]  cnt_o
);

    evt_t evt;
    logic q;

    pwm_leg_timebase #(.CW(CW)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .prd_shadow (prd_shadow_i),
        .cmp_val    (cmp_i),
        .phs_val    (phs_i),
        .phs_en     (phs_en_i),
        .sync_in    (sync_in_i),
        .cnt        (cnt_o),
        .evt        (evt),
        .sync_out   (sync_out_o)
    );

    pwm_leg_qualifier u_aq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .frc_a (frc_a_i),
        .frc_b (frc_b_i),
        .q     (q)
    );

    pwm_leg_deadband #(.DBW(DBW)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .q        (q),
        .rise_dly (rise_dly_i),
        .fall_dly (fall_dly_i),
        .a_o      (pwm_a_o),
        .b_o      (pwm_b_o)
    );

    a_r3_sync_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out_o == (cnt_o == '0));

endmodule

// File: tb/tb_pwm_phase_leg.sv
module tb_pwm_phase_leg;

    localparam int CLK_PERIOD = 10;
    localparam int CW  = 16;
    localparam int DBW = 8;
    localparam logic [1:0] F_NONE = 2'b00, F_LOW = 2'b01, F_HIGH = 2'b10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [CW-1:0]  prd_shadow_i = '0, cmp_i = '0, phs_i = '0;
    logic           phs_en_i = 1'b0, sync_in_i = 1'b0;
    logic [DBW-1:0] rise_dly_i = '0, fall_dly_i = '0;
    logic [1:0]     frc_a_i = F_NONE, frc_b_i = F_NONE;
    logic           pwm_a_o, pwm_b_o, sync_out_o;
    logic [CW-1:0]  cnt_o;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_phase_leg #(.CW(CW), .DBW(DBW)) dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cnt=%0d)", tag, act, exp, cnt_o);
        end
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (int'(cnt_o) != v);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 cnt", cnt_o, 0);
        chk("R11 A", pwm_a_o, 0);
        chk("R11 B", pwm_b_o, 1);
    endtask

    task automatic t_count();
        wait_cnt(0);
        for (int i = 0; i < 22; i++) begin
            chk("R1 count", cnt_o, i % 10);
            chk("R3 sync_out", sync_out_o, (i % 10) == 0);
            @(negedge clk);
        end
    endtask

    task automatic t_wave_nodb();
        wait_cnt(0);
        for (int i = 0; i < 20; i++) begin
            int c = int'(cnt_o);
            chk("R8 A no delay", pwm_a_o, (c >= 2 && c <= 5));
            chk("R8 B complement", pwm_b_o, !(c >= 2 && c <= 5));
            @(negedge clk);
        end
    endtask

    task automatic t_wave_db();
        rise_dly_i = 8'd1; fall_dly_i = 8'd2;
        settle(25);
        wait_cnt(0);
        for (int i = 0; i < 20; i++) begin
            int c = int'(cnt_o);
            chk("R9 A rise delay", pwm_a_o, (c >= 3 && c <= 5));
            chk("R9 B fall delay", pwm_b_o, (c >= 8 || c <= 1));
            chk("R9 exclusive", pwm_a_o & pwm_b_o, 0);
            @(negedge clk);
        end
        rise_dly_i = '0; fall_dly_i = '0;
        settle(25);
    endtask

    task automatic t_cmp_zero();
        cmp_i = 16'd0;
        settle(25);
        for (int i = 0; i < 12; i++) begin
            chk("R7 compare wins", pwm_a_o, 0);
            @(negedge clk);
        end
        cmp_i = 16'd4;
        settle(25);
    endtask

    task automatic t_shadow();
        int mx;
        wait_cnt(3);
        prd_shadow_i = 16'd5;
        mx = 0;
        while (cnt_o != 0) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        chk("R2 old period kept", mx, 9);
        @(negedge clk);
        mx = 0;
        while (cnt_o != 0) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        chk("R2 new period used", mx, 5);
        prd_shadow_i = 16'd9;
        settle(25);
    endtask

    task automatic t_sync_ignored();
        phs_en_i = 1'b0;
        wait_cnt(6);
        phs_i = 16'd2; sync_in_i = 1'b1;
        @(negedge clk);
        sync_in_i = 1'b0;
        chk("R4 sync ignored", cnt_o, 7);
    endtask

    task automatic t_skip_zero();
        phs_en_i = 1'b1;
        wait_cnt(7);
        phs_i = 16'd2; sync_in_i = 1'b1;
        @(negedge clk);
        sync_in_i = 1'b0;
        chk("R4 phase loaded", cnt_o, 2);
        for (int i = 0; i < 10; i++) begin
            chk("R5 zero skipped A", pwm_a_o, 0);
            chk("R5 zero skipped B", pwm_b_o, 1);
            @(negedge clk);
        end
        chk("R5 recovery next period", pwm_a_o, (cnt_o == 2));
        phs_en_i = 1'b0;
    endtask

    task automatic t_skip_cmp();
        phs_en_i = 1'b1;
        wait_cnt(3);
        phs_i = 16'd6; sync_in_i = 1'b1;
        @(negedge clk);
        sync_in_i = 1'b0;
        chk("R4 phase loaded cmp", cnt_o, 6);
        for (int i = 0; i < 4; i++) begin
            chk("R5 compare skipped A", pwm_a_o, 1);
            @(negedge clk);
        end
        phs_en_i = 1'b0;
        settle(25);
    endtask

    task automatic t_load_suppress();
        phs_en_i = 1'b1;
        wait_cnt(0);
        phs_i = 16'd3; sync_in_i = 1'b1;
        @(negedge clk);
        sync_in_i = 1'b0;
        for (int i = 0; i < 7; i++) begin
            chk("R6 no event in load cycle", pwm_a_o, 0);
            @(negedge clk);
        end
        phs_en_i = 1'b0;
        settle(25);
    endtask

    task automatic t_force();
        phs_en_i = 1'b1;
        wait_cnt(7);
        phs_i = 16'd5; sync_in_i = 1'b1;
        @(negedge clk);
        sync_in_i = 1'b0;
        phs_en_i = 1'b0;
        frc_a_i = F_HIGH;
        @(negedge clk);
        frc_a_i = F_NONE;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk("R10 force A high", pwm_a_o, 1);
            chk("R10 force A high B", pwm_b_o, 0);
            @(negedge clk);
        end
        wait_cnt(2);
        frc_b_i = F_HIGH;
        @(negedge clk);
        frc_b_i = F_NONE;
        @(negedge clk);
        chk("R10 force B high cnt", cnt_o, 4);
        chk("R10 force B high A", pwm_a_o, 0);
        chk("R10 force B high B", pwm_b_o, 1);
        wait_cnt(0);
        frc_a_i = F_LOW;
        @(negedge clk);
        frc_a_i = F_NONE;
        for (int i = 0; i < 5; i++) begin
            chk("R10 force overrides zero", pwm_a_o, 0);
            @(negedge clk);
        end
        wait_cnt(0);
        frc_a_i = F_HIGH; frc_b_i = F_HIGH;
        @(negedge clk);
        frc_a_i = F_NONE; frc_b_i = F_NONE;
        @(negedge clk);
        chk("R10 A force wins", pwm_a_o, 1);
        settle(25);
    endtask

    task automatic t_large();
        int a_n = 0, b_n = 0, both = 0, mx = 0;
        prd_shadow_i = 16'd1500; cmp_i = 16'd750;
        rise_dly_i = 8'd60; fall_dly_i = 8'd60;
        settle(3200);
        wait_cnt(0);
        for (int i = 0; i < 1501; i++) begin
            a_n += pwm_a_o;
            b_n += pwm_b_o;
            both += (pwm_a_o & pwm_b_o);
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        chk("R1 large period top", mx, 1500);
        chk("R1 wraps after 1501", cnt_o, 0);
        chk("R9 A high cycles", a_n, 690);
        chk("R9 B high cycles", b_n, 691);
        chk("R9 never both high", both, 0);
    endtask

    initial begin
        t_reset();
        settle(2);
        rst_n = 1'b1;
        prd_shadow_i = 16'd9; cmp_i = 16'd4;
        settle(30);
        t_count();
        t_wave_nodb();
        t_wave_db();
        t_cmp_zero();
        t_shadow();
        t_sync_ignored();
        t_skip_zero();
        t_skip_cmp();
        t_load_suppress();
        t_force();
        t_large();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule